// File: doc/BRIEF.md
# Latched Analog-Mux Switch Controller

This block holds the digital control for a sixteen-input analog multiplexer built in two switching levels. It captures a channel address and three select terms behind a level-sensitive strobe. From the held request it produces gate drives for sixteen first-level T cells. Each cell has two series elements and one shunt element. It also drives one second-level series switch per bank of eight cells, and a status line that is asserted while a channel is connected.

The controller resynchronizes every control input into the clock domain through two flip-flop stages. The request holder follows the inputs while the strobe is high and freezes them while it is low. A sequencer opens the old path and then waits a fixed number of clock cycles, with every cell isolated, before it closes a new path. Two inputs therefore never reach the common output together. A stable flag tells the surrounding logic when the drives match the held request and no gap is running.

Top module: `amux_sw_ctrl`

## Requirements
- R1: With a channel enabled, address value k (binary, 0 to 15) turns on cell k only, meaning bit k of the drive vectors. Address 0 picks bit 0 and address 15 picks bit 15.
- R2: A channel is connected only when en_i is 1, cs_i is 1 and cs_n_i is 0. Each of the other seven combinations leaves every cell off.
- R3: While the synchronized strobe is high, the held request follows the address and select inputs. While it is low, the held request keeps its last value.
- R4: The select result is held together with the address. With the strobe low, changing any select input or the address does not alter the drives.
- R5: For every cell, ser_a_o and ser_c_o are equal and shunt_o is their inverse. An off cell has both series elements open and its shunt closed.
- R6: bank_o[0] is on only when the connected channel is 0 to 7. bank_o[1] is on only when it is 8 to 15. Both banks are off when no channel is connected.
- R7: active_o is 1 exactly when one cell is connected, and 0 otherwise.
- R8: A change away from a connected channel first opens every cell. The cells then stay open for exactly DEAD_CYCLES clock cycles before any cell closes again. Two cells are never on at once, and no drive ever moves directly from one channel to another.
- R9: While rst_n is low, and right after it is released, every cell is off with its shunt closed, both banks are off, and active_o is 0.
- R10: When no channel is connected, an input change made with the strobe high reaches the drives on the fourth rising clock edge after it is applied. It is not visible after the third edge.
- R11: stable_o is 1 when the drives match the held request and no gap is counting. It is 0 during a break-before-make gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Channel address, binary |
| en_i | input | 1 | Enable, active high |
| cs_i | input | 1 | Chip select, active high |
| cs_n_i | input | 1 | Chip select, active low |
| strobe_i | input | 1 | Level strobe: high = follow, low = hold |
| ser_a_o | output | 16 | Input-side series element drive per cell |
| ser_c_o | output | 16 | Output-side series element drive per cell |
| shunt_o | output | 16 | Shunt element drive per cell (1 = closed) |
| bank_o | output | 2 | Second-level bank switch drives |
| active_o | output | 1 | Channel-connected status |
| stable_o | output | 1 | Drives match request, no gap pending |

## Verification
A walk over all sixteen addresses, in order, checks the decode, the bank split and the gap length. Each step is a channel-to-channel change, so it also shows whether the gap is too short or missing. A sweep of all eight select combinations shows whether the gating uses the right polarity on every term. A strobe-low phase, in which the address and an enable are changed, shows whether the hold works for both the address and the select result. A single edge-counted step from the idle state pins down the synchronizer latency, and a sample taken during a gap shows the stable flag dropping.

// File: rtl/amux_pkg.sv
package amux_pkg;
  typedef enum logic [0:0] {
    SEQ_HOLD = 1'b0,
    SEQ_GAP  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/amux_sync.sv
module amux_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg1_q;
  logic [W-1:0] stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= d_i;
      stg2_q <= stg1_q;
    end
  end

  assign q_o = stg2_q;
endmodule

// File: rtl/amux_req_hold.sv
module amux_req_hold #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_s,
  input  logic              en_s,
  input  logic              cs_s,
  input  logic              cs_n_s,
  input  logic [ADDR_W-1:0] addr_s,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o
);
  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              load_en;

  assign load_en = strobe_s;

  always_comb begin
    valid_d = valid_q;
    addr_d  = addr_q;
    if (load_en) begin
      valid_d = en_s & cs_s & ~cs_n_s;
      addr_d  = addr_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
    end
  end

  assign req_valid_o = valid_q;
  assign req_addr_o  = addr_q;
endmodule

// File: rtl/amux_bbm_seq.sv
module amux_bbm_seq
  import amux_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DEAD_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              cur_valid_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              settled_o
);
  localparam int CNT_W = (DEAD_CYCLES < 2) ? 1 : $clog2(DEAD_CYCLES);
  localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(DEAD_CYCLES - 1);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cur_valid_q, cur_valid_d;
  logic [ADDR_W-1:0] cur_addr_q, cur_addr_d;
  logic              differs;

  assign differs = (cur_valid_q != req_valid_i) ||
                   (req_valid_i && (cur_addr_q != req_addr_i));

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    cur_valid_d = cur_valid_q;
    cur_addr_d  = cur_addr_q;
    unique case (state_q)
      SEQ_HOLD: begin
        if (differs) begin
          if (cur_valid_q) begin
            cur_valid_d = 1'b0;
            cnt_d       = GAP_LOAD;
            state_d     = SEQ_GAP;
          end else begin
            cur_valid_d = req_valid_i;
            cur_addr_d  = req_addr_i;
          end
        end
      end
      SEQ_GAP: begin
        if (cnt_q == '0) begin
          cur_valid_d = req_valid_i;
          cur_addr_d  = req_addr_i;
          state_d     = SEQ_HOLD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = SEQ_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SEQ_HOLD;
      cnt_q       <= '0;
      cur_valid_q <= 1'b0;
      cur_addr_q  <= '0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      cur_valid_q <= cur_valid_d;
      cur_addr_q  <= cur_addr_d;
    end
  end

  assign cur_valid_o = cur_valid_q;
  assign cur_addr_o  = cur_addr_q;
  assign settled_o   = (state_q == SEQ_HOLD) && !differs;
endmodule

// File: rtl/amux_drive_dec.sv
module amux_drive_dec #(
  parameter int NUM_CH    = 16,
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 4
) (
  input  logic              cur_valid_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  output logic [NUM_CH-1:0] ser_a_o,
  output logic [NUM_CH-1:0] ser_c_o,
  output logic [NUM_CH-1:0] shunt_o,
  output logic [NUM_BANKS-1:0] bank_o
);
  localparam int BANK_SZ = NUM_CH / NUM_BANKS;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cell
    logic cell_on;
    assign cell_on     = cur_valid_i && (cur_addr_i == ADDR_W'(ch));
    assign ser_a_o[ch] = cell_on;
    assign ser_c_o[ch] = cell_on;
    assign shunt_o[ch] = ~cell_on;
  end

  for (genvar bk = 0; bk < NUM_BANKS; bk++) begin : g_bank
    assign bank_o[bk] = cur_valid_i &&
                        ((32'(cur_addr_i) / BANK_SZ) == bk);
  end
endmodule

// File: rtl/amux_sw_ctrl.sv
module amux_sw_ctrl #(
  parameter int NUM_CH      = 16,
  parameter int NUM_BANKS   = 2,
  parameter int DEAD_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           addr_i,
  input  logic                 en_i,
  input  logic                 cs_i,
  input  logic                 cs_n_i,
  input  logic                 strobe_i,
  output logic [NUM_CH-1:0]    ser_a_o,
  output logic [NUM_CH-1:0]    ser_c_o,
  output logic [NUM_CH-1:0]    shunt_o,
  output logic [NUM_BANKS-1:0] bank_o,
  output logic                 active_o,
  output logic                 stable_o
);
  localparam int ADDR_W = $clog2(NUM_CH);
  localparam int SYNC_W = ADDR_W + 4;

  logic [SYNC_W-1:0] sync_in, sync_out;
  logic              strobe_s, en_s, cs_s, cs_n_s;
  logic [ADDR_W-1:0] addr_s;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic              cur_valid;
  logic [ADDR_W-1:0] cur_addr;

  assign sync_in = {strobe_i, en_i, cs_i, cs_n_i, addr_i[ADDR_W-1:0]};
  assign {strobe_s, en_s, cs_s, cs_n_s, addr_s} = sync_out;

  amux_sync #(.W(SYNC_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (sync_in),
    .q_o   (sync_out)
  );

  amux_req_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe_s    (strobe_s),
    .en_s        (en_s),
    .cs_s        (cs_s),
    .cs_n_s      (cs_n_s),
    .addr_s      (addr_s),
    .req_valid_o (req_valid),
    .req_addr_o  (req_addr)
  );

  amux_bbm_seq #(.ADDR_W(ADDR_W), .DEAD_CYCLES(DEAD_CYCLES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid),
    .req_addr_i  (req_addr),
    .cur_valid_o (cur_valid),
    .cur_addr_o  (cur_addr),
    .settled_o   (stable_o)
  );

  amux_drive_dec #(.NUM_CH(NUM_CH), .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
    .cur_valid_i (cur_valid),
    .cur_addr_i  (cur_addr),
    .ser_a_o     (ser_a_o),
    .ser_c_o     (ser_c_o),
    .shunt_o     (shunt_o),
    .bank_o      (bank_o)
  );

  assign active_o = cur_valid;
endmodule

// File: rtl/amux_sw_ctrl_chk.sv
module amux_sw_ctrl_chk #(
  parameter int NUM_CH      = 16,
  parameter int NUM_BANKS   = 2,
  parameter int DEAD_CYCLES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CH-1:0]    ser_a_o,
  input logic [NUM_CH-1:0]    ser_c_o,
  input logic [NUM_CH-1:0]    shunt_o,
  input logic [NUM_BANKS-1:0] bank_o,
  input logic                 active_o,
  input logic                 stable_o
);
  localparam int GW = $clog2(DEAD_CYCLES + 2);
  localparam logic [GW-1:0] GAP_MAX = GW'(DEAD_CYCLES);

  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (ser_a_o != '0) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != GAP_MAX) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R8
  onehot_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ser_a_o));

  // R5
  series_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_a_o == ser_c_o) && (shunt_o == ~ser_a_o));

  // R8
  no_direct_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_a_o != '0) |=> ((ser_a_o == '0) || $stable(ser_a_o)));

  // R8
  gap_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && ser_a_o != '0 && gap_q != '0) |-> (gap_q >= GAP_MAX));

  // R7
  active_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_o == (ser_a_o != '0));

  // R6
  bank_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_o ? $onehot(bank_o) : (bank_o == '0));

  // R11
  stable_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && ser_a_o == '0 && gap_q < GAP_MAX && gap_q != '0) |-> !stable_o);
endmodule

bind amux_sw_ctrl amux_sw_ctrl_chk #(
  .NUM_CH(NUM_CH), .NUM_BANKS(NUM_BANKS), .DEAD_CYCLES(DEAD_CYCLES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ser_a_o  (ser_a_o),
  .ser_c_o  (ser_c_o),
  .shunt_o  (shunt_o),
  .bank_o   (bank_o),
  .active_o (active_o),
  .stable_o (stable_o)
);

// File: tb/amux_sw_ctrl_bench.sv
`timescale 1ns/1ps
module amux_sw_ctrl_bench;
  localparam int NCH  = 16;
  localparam int DEAD = 4;

  logic            clk;
  logic            rst_n;
  logic [3:0]      addr_i;
  logic            en_i, cs_i, cs_n_i, strobe_i;
  logic [NCH-1:0]  ser_a_o, ser_c_o, shunt_o;
  logic [1:0]      bank_o;
  logic            active_o, stable_o;

  int checks = 0;
  int errors = 0;

  amux_sw_ctrl #(.NUM_CH(NCH), .NUM_BANKS(2), .DEAD_CYCLES(DEAD)) u_amux_sw_ctrl (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .en_i(en_i), .cs_i(cs_i),
    .cs_n_i(cs_n_i), .strobe_i(strobe_i), .ser_a_o(ser_a_o), .ser_c_o(ser_c_o),
    .shunt_o(shunt_o), .bank_o(bank_o), .active_o(active_o), .stable_o(stable_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // gap monitor
  logic [NCH-1:0] prev_ser;
  int gap_cnt, last_gap, direct_sw;
  bit seen_on;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ser = '0; gap_cnt = 0; seen_on = 0; last_gap = -1;
    end else begin
      if (ser_a_o != '0) begin
        if (prev_ser != '0 && prev_ser != ser_a_o) direct_sw++;
        if (prev_ser == '0 && seen_on) last_gap = gap_cnt;
        gap_cnt = 0;
        seen_on = 1;
      end else begin
        gap_cnt++;
      end
      prev_ser = ser_a_o;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  task automatic check_chan(input int ch, input string tag);
    logic [NCH-1:0] exp;
    exp = (ch < 0) ? '0 : (NCH'(1) << ch);
    chk(ser_a_o == exp, {tag, " ser_a"}, ser_a_o, exp);
    chk(ser_c_o == exp && shunt_o == ~exp, {tag, " R5 pair"}, {ser_c_o, shunt_o}, {exp, ~exp});
    chk(active_o == (ch >= 0), {tag, " R7 active"}, active_o, ch >= 0);
    chk(bank_o == ((ch < 0) ? 2'b00 : (ch < 8) ? 2'b01 : 2'b10), {tag, " R6 bank"},
        bank_o, (ch < 0) ? 0 : (ch < 8) ? 1 : 2);
  endtask

  task automatic t_reset();
    rst_n = 0; addr_i = 4'd7; en_i = 1; cs_i = 1; cs_n_i = 0; strobe_i = 1;
    repeat (3) @(negedge clk);
    check_chan(-1, "R9 in reset");
    rst_n = 1;
    @(negedge clk);
    check_chan(-1, "R9 after release");
    settle();
  endtask

  task automatic t_decode();
    for (int a = 0; a < NCH; a++) begin
      addr_i = 4'(a);
      settle();
      check_chan(a, "R1 decode");
      chk(stable_o == 1'b1, "R11 settled", stable_o, 1);
      if (a > 0) chk(last_gap == DEAD, "R8 gap length", last_gap, DEAD);
    end
    chk(direct_sw == 0, "R8 no direct switch", direct_sw, 0);
  endtask

  task automatic t_gap_sample();
    addr_i = 4'd3;
    settle();
    addr_i = 4'd12;
    repeat (5) @(negedge clk);
    chk(ser_a_o == '0, "R8 open during gap", ser_a_o, 0);
    chk(stable_o == 1'b0, "R11 low during gap", stable_o, 0);
    settle();
    check_chan(12, "R8 after gap");
  endtask

  task automatic t_select();
    for (int c = 0; c < 8; c++) begin
      en_i = c[2]; cs_i = c[1]; cs_n_i = c[0];
      addr_i = 4'd9;
      settle();
      check_chan((c == 6) ? 9 : -1, "R2 select gate");
    end
    en_i = 1; cs_i = 1; cs_n_i = 0;
    settle();
  endtask

  task automatic t_hold();
    strobe_i = 1; addr_i = 4'd2;
    settle();
    strobe_i = 0;
    settle();
    addr_i = 4'd10; en_i = 0; cs_n_i = 1;
    settle();
    check_chan(2, "R4 R3 held while strobe low");
    strobe_i = 1;
    settle();
    check_chan(-1, "R3 follows on strobe high");
    en_i = 1; cs_n_i = 0;
    settle();
    check_chan(10, "R3 transparent");
  endtask

  task automatic t_latency();
    cs_n_i = 1;
    settle();
    check_chan(-1, "R10 idle");
    cs_n_i = 0; addr_i = 4'd5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(active_o == 1'b0, "R10 not before 4th edge", active_o, 0);
    @(posedge clk);
    @(negedge clk);
    chk(ser_a_o == (NCH'(1) << 5), "R10 on 4th edge", ser_a_o, NCH'(1) << 5);
    settle();
  endtask

  initial begin
    #(20ns * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    direct_sw = 0;
    t_reset();
    t_decode();
    t_gap_sample();
    t_select();
    t_hold();
    t_latency();
    chk(direct_sw == 0, "R8 no direct switch overall", direct_sw, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule